// File: doc/BRIEF.md
# Two-Subphase Address Parity Unit

This block produces and verifies the pair of active-low parity bits that go with a request on a split-phase processor request bus. Each request is sent in two consecutive subphases. The first subphase carries the address field, and the second carries the transaction type. In both subphases the address field and the 5-bit request-type field are covered. The parity bits are split between two signal groups:

- the upper address slice, bits 35..24;
- the lower address slice, bits 23..3, together with the request-type field.

Which parity bit guards which group reverses from one subphase to the next.

Parity is counted over asserted (low) levels. A parity line is correct when it is high for an even count of low inputs in its group, so a group that is all high gives a high parity line. In generate mode the two parity lines follow the inputs in the same cycle, which lets the request initiator drive them together with the strobe, the address and the type. In check mode the parity outputs rest high. The block compares the received parity lines with its own in the cycles that hold a valid subphase, and it reports a registered one-cycle error pulse with a 2-bit mask that shows which bit failed.

Top module: `addr_parity_unit`

## Requirements
- R1: With `sub2_i` low, `par_n_o[0]` is the parity of address bits 35..24 (`addr_n_i[32:21]`). `par_n_o[1]` is the parity of address bits 23..3 (`addr_n_i[20:0]`) together with `rtype_n_i[4:0]`.
- R2: With `sub2_i` high, the two groups swap. `par_n_o[0]` covers address bits 23..3 plus the request type, and `par_n_o[1]` covers address bits 35..24.
- R3: A parity bit is 1 when an even number of its covered inputs are 0, and 0 when that number is odd. When every covered input is 1, the parity bit is 1.
- R4: In generate mode (`chk_mode_i` = 0, out of reset), `par_n_o` changes in the same cycle as its inputs, with no register in the path.
- R5: In check mode (`chk_mode_i` = 1), `par_n_o` is held at 2'b11.
- R6: A subphase-1 check happens in a cycle where `chk_mode_i` = 1, `strb_n_i` = 0 and `sub2_i` = 0. On the next clock edge, `err_mask_o[i]` becomes 1 exactly when `rcv_par_n_i[i]` differs from the subphase-1 parity of bit i.
- R7: A subphase-2 check happens in a cycle where `chk_mode_i` = 1 and `sub2_i` = 1, and `strb_n_i` was 0 in the previous cycle. The mask is computed against the subphase-2 coverage and is reported on the next edge.
- R8: In every other cycle the received parity is ignored, and `err_o` and `err_mask_o` are 0 after the next edge. This includes generate mode, `sub2_i` high without a strobe in the previous cycle, and `sub2_i` low without a strobe.
- R9: While `rst_n_i` is low, `par_n_o` = 2'b11, `err_o` = 0 and `err_mask_o` = 0. The cycle just after reset release has no previous strobe.
- R10: `err_o` is 1 exactly when `err_mask_o` is nonzero, and it lasts one cycle unless the following cycle also checks with a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| chk_mode_i | input | 1 | 0: generate parity, 1: check received parity |
| strb_n_i | input | 1 | Active-low request strobe (first subphase cycle) |
| sub2_i | input | 1 | 1 selects second-subphase coverage |
| addr_n_i | input | 33 | Active-low address, index 0 = address bit 3 |
| rtype_n_i | input | 5 | Active-low request type |
| rcv_par_n_i | input | 2 | Received parity lines, index = parity bit |
| par_n_o | output | 2 | Generated parity lines |
| err_o | output | 1 | Registered parity error pulse |
| err_mask_o | output | 2 | Registered mask of the failing parity bits |

## Verification
The only internal state is the delayed strobe and the error register. If the delayed strobe is wrong, a second-subphase check is lost or added, and this shows on `err_o` one edge after the affected cycle. If the error register is wrong, the mask shows a wrong bit on that same next edge. Errors in the coverage mapping or in the parity polarity need no clock to appear: they show on `par_n_o` in the cycle the inputs change. Random traffic with a mix of strobes, subphase selects and corrupted received parity reaches both checking windows and the cycles outside them.

// File: rtl/apu_pkg.sv
package apu_pkg;
  parameter int ADDR_W = 33;  // address bits 35..3
  parameter int REQ_W  = 5;   // request type width
  parameter int HI_W   = 12;  // upper slice, address bits 35..24
  parameter int NPAR   = 2;   // parity lines
  typedef logic [NPAR-1:0] par_t;
endpackage

// File: rtl/apu_grp_parity.sv
// Parity over active-low levels: 1 when the count of low inputs is even.
module apu_grp_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] grp_n_i,
  output logic         par_n_o
);
  logic [W-1:0] low_flags;
  always_comb begin
    low_flags = ~grp_n_i;
    par_n_o   = ~(^low_flags);
  end
endmodule

// File: rtl/apu_window.sv
// Decides whether the current cycle carries a checkable subphase.
module apu_window (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic chk_mode_i,
  input  logic strb_n_i,
  input  logic sub2_i,
  output logic chk_vld_o
);
  logic strb_q, strb_d;

  always_comb begin
    strb_d    = ~strb_n_i;
    chk_vld_o = chk_mode_i & ((~strb_n_i & ~sub2_i) | (strb_q & sub2_i));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) strb_q <= 1'b0;
    else          strb_q <= strb_d;
  end
endmodule

// File: rtl/apu_err_reg.sv
// Registers the mismatch mask for one cycle.
module apu_err_reg #(
  parameter int NPAR = 2
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            vld_i,
  input  logic [NPAR-1:0] exp_n_i,
  input  logic [NPAR-1:0] rcv_n_i,
  output logic            err_o,
  output logic [NPAR-1:0] mask_o
);
  logic [NPAR-1:0] mask_d;
  logic            err_d;

  always_comb begin
    mask_d = vld_i ? (exp_n_i ^ rcv_n_i) : '0;
    err_d  = |mask_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_o <= '0;
      err_o  <= 1'b0;
    end else begin
      mask_o <= mask_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit #(
  parameter int ADDR_W = apu_pkg::ADDR_W,
  parameter int REQ_W  = apu_pkg::REQ_W,
  parameter int HI_W   = apu_pkg::HI_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              chk_mode_i,
  input  logic              strb_n_i,
  input  logic              sub2_i,
  input  logic [ADDR_W-1:0] addr_n_i,
  input  logic [REQ_W-1:0]  rtype_n_i,
  input  logic [1:0]        rcv_par_n_i,
  output logic [1:0]        par_n_o,
  output logic              err_o,
  output logic [1:0]        err_mask_o
);
  localparam int LO_W = ADDR_W - HI_W;
  localparam int LB_W = LO_W + REQ_W;

  logic                hi_par_n, lo_par_n, chk_vld;
  apu_pkg::par_t       exp_par_n;
  logic [LB_W-1:0]     lo_grp_n;

  always_comb lo_grp_n = {rtype_n_i, addr_n_i[LO_W-1:0]};

  apu_grp_parity #(.W(HI_W)) u_hi (.grp_n_i(addr_n_i[ADDR_W-1:LO_W]), .par_n_o(hi_par_n));
  apu_grp_parity #(.W(LB_W)) u_lo (.grp_n_i(lo_grp_n), .par_n_o(lo_par_n));

  // Coverage swap: bit 0 takes the upper slice in subphase 1, bit 1 in subphase 2.
  for (genvar g = 0; g < 2; g++) begin : g_map
    always_comb exp_par_n[g] = ((g == 0) ^ sub2_i) ? hi_par_n : lo_par_n;
  end

  always_comb par_n_o = (!rst_n_i || chk_mode_i) ? 2'b11 : exp_par_n;

  apu_window u_win (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .chk_mode_i(chk_mode_i),
    .strb_n_i(strb_n_i), .sub2_i(sub2_i), .chk_vld_o(chk_vld)
  );

  apu_err_reg #(.NPAR(2)) u_err (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .vld_i(chk_vld),
    .exp_n_i(exp_par_n), .rcv_n_i(rcv_par_n_i),
    .err_o(err_o), .mask_o(err_mask_o)
  );
endmodule

// File: rtl/apu_checker.sv
module apu_checker (
  input logic        clk_i,
  input logic        rst_n_i,
  input logic        chk_mode_i,
  input logic        strb_n_i,
  input logic        sub2_i,
  input logic [32:0] addr_n_i,
  input logic [4:0]  rtype_n_i,
  input logic [1:0]  rcv_par_n_i,
  input logic [1:0]  par_n_o,
  input logic        err_o,
  input logic [1:0]  err_mask_o
);
  logic hi_p, lo_p;
  always_comb begin
    hi_p = ~(^(~addr_n_i[32:21]));
    lo_p = ~(^(~{rtype_n_i, addr_n_i[20:0]}));
  end

  a_r1_sub1_map: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!chk_mode_i && !sub2_i) |-> (par_n_o == {lo_p, hi_p}));
  a_r2_sub2_map: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!chk_mode_i && sub2_i) |-> (par_n_o == {hi_p, lo_p}));
  a_r5_check_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    chk_mode_i |-> (par_n_o == 2'b11));
  a_r6_sub1_mask: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (chk_mode_i && !strb_n_i && !sub2_i) |=> (err_mask_o == $past(rcv_par_n_i ^ {lo_p, hi_p})));
  a_r8_gen_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !chk_mode_i |=> (err_mask_o == 2'b00));
  a_r8_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strb_n_i && !sub2_i) |=> !err_o);
  a_r10_pulse_mask: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    err_o |-> (err_mask_o != 2'b00));
  always_comb begin
    if (!rst_n_i) a_r9_reset_idle: assert (par_n_o == 2'b11 && !err_o && err_mask_o == 2'b00);
  end
endmodule

bind addr_parity_unit apu_checker u_chk (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .chk_mode_i(chk_mode_i), .strb_n_i(strb_n_i),
  .sub2_i(sub2_i), .addr_n_i(addr_n_i), .rtype_n_i(rtype_n_i),
  .rcv_par_n_i(rcv_par_n_i), .par_n_o(par_n_o), .err_o(err_o), .err_mask_o(err_mask_o)
);

// File: tb/addr_parity_unit_test.sv
module addr_parity_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode, strb_n, sub2;
  logic [32:0] addr_n;
  logic [4:0]  rtype_n;
  logic [1:0]  rcv_n;
  logic [1:0]  par_n;
  logic        err;
  logic [1:0]  mask;
  int          n_chk = 0, n_fail = 0;
  logic        prev_strb;
  logic [1:0]  pend_mask;

  always #5 clk = ~clk;

  addr_parity_unit uut (
    .clk_i(clk), .rst_n_i(rst_n), .chk_mode_i(mode), .strb_n_i(strb_n), .sub2_i(sub2),
    .addr_n_i(addr_n), .rtype_n_i(rtype_n), .rcv_par_n_i(rcv_n),
    .par_n_o(par_n), .err_o(err), .err_mask_o(mask)
  );

  function automatic logic even_low(input logic [37:0] v, input int w);
    int lows = 0;
    for (int i = 0; i < w; i++) if (!v[i]) lows++;
    return (lows % 2) == 0;
  endfunction

  function automatic logic [1:0] model_par(input logic [32:0] a, input logic [4:0] r, input logic s2);
    logic hi, lo;
    hi = even_low({26'h3ffffff, a[32:21]}, 12);
    lo = even_low({12'hfff, r, a[20:0]}, 26);
    return s2 ? {hi, lo} : {lo, hi};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge: check registered outputs from the last cycle, apply inputs,
  // check combinational parity, record the expectation for the next edge.
  task automatic step(input logic m, input logic s_n, input logic s2,
                      input logic [32:0] a, input logic [4:0] r, input logic [1:0] rc,
                      input string req);
    logic vld;
    @(negedge clk);
    check("R10 err/mask", {1'b0, err, mask}, {1'b0, |pend_mask, pend_mask});
    mode = m; strb_n = s_n; sub2 = s2; addr_n = a; rtype_n = r; rcv_n = rc;
    #1;
    check(req, {2'b00, par_n}, {2'b00, m ? 2'b11 : model_par(a, r, s2)});
    vld = m & ((!s_n & !s2) | (prev_strb & s2));
    pend_mask = vld ? (rc ^ model_par(a, r, s2)) : 2'b00;
    prev_strb = !s_n;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] good;
    void'($urandom(32'd777));
    rst_n = 1'b0; mode = 1'b0; strb_n = 1'b0; sub2 = 1'b0;
    addr_n = 33'h0_1234_5678; rtype_n = 5'h0a; rcv_n = 2'b00;
    prev_strb = 1'b0; pend_mask = 2'b00;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset outputs", {err, mask, par_n[0]}, 4'b0001);
    check("R9 reset parity", {2'b00, par_n}, 4'b0011);
    @(negedge clk); rst_n = 1'b1;

    // R3: all high gives high parity in both subphases
    step(1'b0, 1'b1, 1'b0, '1, '1, 2'b00, "R3 all high sub1");
    step(1'b0, 1'b1, 1'b1, '1, '1, 2'b00, "R3 all high sub2");
    // R1: single low in upper slice flips bit 0 only
    step(1'b0, 1'b0, 1'b0, ~(33'h1 << 32), '1, 2'b00, "R1 upper slice sub1");
    // R2: same input in subphase 2 flips bit 1 only
    step(1'b0, 1'b1, 1'b1, ~(33'h1 << 32), '1, 2'b00, "R2 upper slice sub2");
    // R1/R3: one low request-type bit lands in the lower group, two lows cancel
    step(1'b0, 1'b1, 1'b0, '1, 5'b11110, 2'b00, "R1 request type low");
    step(1'b0, 1'b1, 1'b0, ~33'h3, '1, 2'b00, "R3 two lows even");
    // R4: generate mode parity follows inputs in the same cycle
    step(1'b0, 1'b1, 1'b1, ~33'h1, '1, 2'b00, "R4 same cycle");
    // R6: subphase 1 check with bit 1 corrupted
    good = model_par(33'h0_0f0f_0f0f, 5'h13, 1'b0);
    step(1'b1, 1'b0, 1'b0, 33'h0_0f0f_0f0f, 5'h13, good ^ 2'b10, "R5 check quiet");
    // R7: subphase 2 right after, bit 0 corrupted
    good = model_par(33'h1_ffff_0000, 5'h05, 1'b1);
    step(1'b1, 1'b1, 1'b1, 33'h1_ffff_0000, 5'h05, good ^ 2'b01, "R7 sub2 window");
    // R8: subphase 2 without prior strobe is ignored
    step(1'b1, 1'b1, 1'b1, 33'h0, 5'h0, 2'b01, "R8 sub2 no strobe");
    // R8: generate mode ignores received parity
    step(1'b0, 1'b0, 1'b0, 33'h0, 5'h0, 2'b10, "R8 generate ignores");
    // R10: good parity on a strobe gives no pulse
    good = model_par(33'h0_aaaa_5555, 5'h1c, 1'b0);
    step(1'b1, 1'b0, 1'b0, 33'h0_aaaa_5555, 5'h1c, good, "R6 clean strobe");

    for (int k = 0; k < 400; k++) begin
      logic m, s_n, s2;
      logic [32:0] a;
      logic [4:0] r;
      logic [1:0] rc;
      m = $urandom_range(0, 3) != 0;
      s_n = $urandom_range(0, 1);
      s2 = $urandom_range(0, 1);
      a = {$urandom_range(0, 1), $urandom()};
      r = 5'($urandom());
      rc = model_par(a, r, s2) ^ (($urandom_range(0, 2) == 0) ? 2'($urandom()) : 2'b00);
      step(m, s_n, s2, a, r, rc, "R6/R7 random");
    end
    step(1'b0, 1'b1, 1'b0, '1, '1, 2'b00, "R8 drain");
    step(1'b0, 1'b1, 1'b0, '1, '1, 2'b00, "R8 drain");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule